// File: doc/BRIEF.md
# Link Fault Status Monitor

This block watches the receive side of a ten-gigabit, four-lane media interface and decides whether the link is healthy, faulted at the local end or faulted at the remote end. Each accepted column is 32 data bits and four control bits, one byte and one control bit per lane. The block picks out fault sequence ordered sets and counts them. It compares their spacing against a column counter that runs on its own, and it holds a two-bit status that the transmit side reads to choose what to send.

The column counter advances once for every accepted column, and no state action ever increments it. The state machine only clears it. A clear happens whenever a fault sequence is accepted, which covers every entry into the counting state and into the fault state. A fault is declared when more than three sequences of one kind arrive with no gap longer than the column limit. The fault is withdrawn after more columns than the limit go by without a sequence. Columns arrive on an internal single-edge interface and are qualified by a valid strobe.

Top module: `lfs_monitor`

## Requirements
- R1: After reset the status output is 00 (link OK) and the block waits for its first fault sequence.
- R2: A column is a fault sequence only in this case: lane 0 byte (bits 7:0) is 0x9C with control bit 0 set, control bits 3:1 are clear, bytes at bits 15:8 and 23:16 are 0x00, and the byte at bits 31:24 is 0x01 (local) or 0x02 (remote). Any other column counts as an ordinary column.
- R3: The status output is 00 for OK, 01 for local fault and 10 for remote fault, and it never takes the value 11.
- R4: The fourth sequence of one kind sets the status to that kind, visible after the clock edge that accepts it, provided that every gap between consecutive sequences is at most 127 ordinary accepted columns. Three such sequences leave the status at 00.
- R5: While sequences are being counted, 128 ordinary accepted columns after the latest sequence discard the count. A gap of exactly 127 does not.
- R6: While sequences are being counted, a sequence of the other kind restarts the count at one with the new kind.
- R7: In the fault state, each sequence of the fault's kind restarts the column count. The status returns to 00 on the 128th ordinary accepted column after the latest sequence and not before.
- R8: In the fault state, a sequence of the other kind sets the status to 00 at once and starts a new count of one with that kind, so three more are needed for a fault of the new kind.
- R9: Columns with the valid strobe low are ignored: they neither advance the column counter nor count as sequences, and the status does not change on them.
- R10: The column counter reads zero on every entry into the counting state or the fault state, and it never passes 127 while either state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | A column is offered in this cycle |
| col_data | input | 32 | Four lane bytes, lane 0 in bits 7:0 |
| col_ctrl | input | 4 | Control bit per lane, lane 0 in bit 0 |
| fault_status | output | 2 | 00 OK, 01 local fault, 10 remote fault |

## Verification
The gap between sequences is swept across 0, 1, 2, 64, 126, 127 and 128 columns for both fault kinds. This separates a correct counter limit from an off-by-one in either direction, and it shows that three sequences never suffice. The lane 3 code is swept over sixteen values, and single-field corruptions of a valid sequence show that only the two exact encodings are recognised. Mixed-kind patterns in the counting and fault states tell a true restart apart from accumulation across kinds. Long runs with the strobe low, placed between sequences and inside a fault, tell a counter gated by the strobe apart from one that runs on every clock.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [1:0] {
        LF_OK     = 2'b00,
        LF_LOCAL  = 2'b01,
        LF_REMOTE = 2'b10
    } lf_kind_e;

    typedef enum logic [1:0] {
        S_INIT  = 2'b00,
        S_COUNT = 2'b01,
        S_FAULT = 2'b10
    } lf_state_e;

    localparam logic [7:0] SEQ_CHAR    = 8'h9C;
    localparam logic [7:0] LOCAL_CODE  = 8'h01;
    localparam logic [7:0] REMOTE_CODE = 8'h02;

endpackage

// File: rtl/lfs_seq_detect.sv
module lfs_seq_detect
    import lfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    output logic                    seq_hit,
    output lf_kind_e                seq_kind
);
    localparam int LAST = LANES - 1;

    logic [LANES-1:0]  lane_ok;
    logic [LANE_W-1:0] code;

    assign code = col_data[LAST*LANE_W +: LANE_W];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_first
                assign lane_ok[g] = col_ctrl[g] &&
                                    (col_data[g*LANE_W +: LANE_W] == LANE_W'(SEQ_CHAR));
            end else if (g == LAST) begin : g_last
                assign lane_ok[g] = !col_ctrl[g] &&
                                    ((code == LANE_W'(LOCAL_CODE)) ||
                                     (code == LANE_W'(REMOTE_CODE)));
            end else begin : g_mid
                assign lane_ok[g] = !col_ctrl[g] &&
                                    (col_data[g*LANE_W +: LANE_W] == '0);
            end
        end
    endgenerate

    assign seq_hit  = &lane_ok;
    assign seq_kind = (code == LANE_W'(LOCAL_CODE)) ? LF_LOCAL : LF_REMOTE;

endmodule

// File: rtl/lfs_col_timer.sv
module lfs_col_timer #(
    parameter int COL_LIMIT = 127,
    parameter int CNT_W     = $clog2(COL_LIMIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_valid,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(COL_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (col_valid) begin
            if (clr)
                nxt_d.cnt = '0;
            else if (cur_q.cnt != CNT_MAX)
                nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_o    = cur_q.cnt;
    assign expire_o = col_valid && !clr && (cur_q.cnt >= LIMIT);

    // R9: a cycle without a column leaves the counter alone
    a_r9_hold_without_column: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |=> $stable(cur_q.cnt));

    // R10: the counter steps by one per accepted column unless cleared
    a_r10_free_running_step: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !clr && cur_q.cnt != CNT_MAX) |=>
            (cur_q.cnt == CNT_W'($past(cur_q.cnt) + 1'b1)));

endmodule

// File: rtl/lfs_fsm.sv
module lfs_fsm
    import lfs_pkg::*;
#(
    parameter int SEQ_LIMIT = 3,
    parameter int SC_W      = $clog2(SEQ_LIMIT + 2)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      col_valid,
    input  logic      seq_hit,
    input  lf_kind_e  seq_kind,
    input  logic      expire,
    output logic      clr_o,
    output lf_state_e state_o,
    output lf_kind_e  status_o
);
    localparam logic [SC_W-1:0] LIMIT = SC_W'(SEQ_LIMIT);

    typedef struct packed {
        lf_state_e       state;
        lf_kind_e        kind;
        logic [SC_W-1:0] seq_cnt;
        lf_kind_e        status;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (col_valid) begin
            case (cur_q.state)
                S_INIT: begin
                    if (seq_hit) begin
                        nxt_d.state   = S_COUNT;
                        nxt_d.kind    = seq_kind;
                        nxt_d.seq_cnt = SC_W'(1);
                    end
                end
                S_COUNT: begin
                    if (seq_hit) begin
                        if (seq_kind != cur_q.kind) begin
                            nxt_d.kind    = seq_kind;
                            nxt_d.seq_cnt = SC_W'(1);
                        end else if (cur_q.seq_cnt >= LIMIT) begin
                            nxt_d.state  = S_FAULT;
                            nxt_d.status = cur_q.kind;
                        end else begin
                            nxt_d.seq_cnt = cur_q.seq_cnt + 1'b1;
                        end
                    end else if (expire) begin
                        nxt_d.state   = S_INIT;
                        nxt_d.seq_cnt = '0;
                    end
                end
                S_FAULT: begin
                    if (seq_hit) begin
                        if (seq_kind != cur_q.kind) begin
                            nxt_d.state   = S_COUNT;
                            nxt_d.kind    = seq_kind;
                            nxt_d.seq_cnt = SC_W'(1);
                            nxt_d.status  = LF_OK;
                        end
                    end else if (expire) begin
                        nxt_d.state   = S_INIT;
                        nxt_d.seq_cnt = '0;
                        nxt_d.status  = LF_OK;
                    end
                end
                default: begin
                    nxt_d.state  = S_INIT;
                    nxt_d.status = LF_OK;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state   <= S_INIT;
            cur_q.kind    <= LF_LOCAL;
            cur_q.seq_cnt <= '0;
            cur_q.status  <= LF_OK;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clr_o    = col_valid && seq_hit;
    assign state_o  = cur_q.state;
    assign status_o = cur_q.status;

    // R3: the encoding 11 never appears
    a_r3_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.status != 2'b11);

    // R3: status moves only when the fault state is entered or left
    a_r3_status_at_fault_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.status != $past(cur_q.status)) |->
            ((cur_q.state == S_FAULT) != ($past(cur_q.state) == S_FAULT)));

    // R9: status is frozen across a cycle with no column
    a_r9_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(col_valid) |-> $stable(cur_q.status));

endmodule

// File: rtl/lfs_monitor.sv
module lfs_monitor
    import lfs_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int COL_LIMIT = 127,
    parameter int SEQ_LIMIT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    col_valid,
    input  logic [LANES*LANE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    output logic [1:0]              fault_status
);
    localparam int CNT_W = $clog2(COL_LIMIT + 2);

    logic             seq_hit;
    lf_kind_e         seq_kind;
    logic             clr;
    logic             expire;
    logic [CNT_W-1:0] col_cnt;
    lf_state_e        state;
    lf_kind_e         status;

    lfs_seq_detect #(.LANES(LANES), .LANE_W(LANE_W)) u_detect (
        .col_data (col_data),
        .col_ctrl (col_ctrl),
        .seq_hit  (seq_hit),
        .seq_kind (seq_kind)
    );

    lfs_col_timer #(.COL_LIMIT(COL_LIMIT), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_valid (col_valid),
        .clr       (clr),
        .cnt_o     (col_cnt),
        .expire_o  (expire)
    );

    lfs_fsm #(.SEQ_LIMIT(SEQ_LIMIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_valid (col_valid),
        .seq_hit   (seq_hit),
        .seq_kind  (seq_kind),
        .expire    (expire),
        .clr_o     (clr),
        .state_o   (state),
        .status_o  (status)
    );

    assign fault_status = status;

    // R10: the counter is zero on every entry into counting or fault
    a_r10_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != $past(state)) && (state != S_INIT)) |-> (col_cnt == '0));

    // R10: the counter never passes the limit outside the idle state
    a_r10_bounded_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_INIT) |-> (col_cnt <= CNT_W'(COL_LIMIT)));

endmodule

// File: tb/sim_lfs_monitor.sv
module sim_lfs_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        col_valid = 1'b0;
    logic [31:0] col_data = 32'h0707_0707;
    logic [3:0]  col_ctrl = 4'hF;
    logic [1:0]  fault_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] IDLE_D = 32'h0707_0707;
    localparam logic [3:0]  IDLE_C = 4'hF;

    always #2 clk = ~clk;

    lfs_monitor u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .col_valid    (col_valid),
        .col_data     (col_data),
        .col_ctrl     (col_ctrl),
        .fault_status (fault_status)
    );

    task automatic chk(input logic [1:0] exp, input string tag);
        checks++;
        if (fault_status !== exp) begin
            errors++;
            $display("FAIL %s: status actual %b expected %b", tag, fault_status, exp);
        end
    endtask

    task automatic col(input logic v, input logic [31:0] d, input logic [3:0] c);
        col_valid = v;
        col_data  = d;
        col_ctrl  = c;
        @(posedge clk);
        #1;
        col_valid = 1'b0;
        col_data  = IDLE_D;
        col_ctrl  = IDLE_C;
    endtask

    task automatic seq(input logic [7:0] code);
        col(1'b1, {code, 8'h00, 8'h00, 8'h9C}, 4'b0001);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) col(1'b1, IDLE_D, IDLE_C);
    endtask

    task automatic flush();
        idle(300);
    endtask

    function automatic logic [1:0] code_to_status(input logic [7:0] code);
        if (code == 8'h01) return 2'b01;
        if (code == 8'h02) return 2'b10;
        return 2'b00;
    endfunction

    initial begin
        int gaps[7] = '{0, 1, 2, 64, 126, 127, 128};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(2'b00, "R1 reset");

        // R4 / R5: gap sweep for both kinds
        for (int k = 1; k <= 2; k++) begin
            for (int gi = 0; gi < 7; gi++) begin
                flush();
                for (int s = 0; s < 4; s++) begin
                    seq(8'(k));
                    if (s == 2) chk(2'b00, "R4 three sequences not enough");
                    if (s < 3) idle(gaps[gi]);
                end
                chk((gaps[gi] <= 127) ? code_to_status(8'(k)) : 2'b00,
                    (gaps[gi] <= 127) ? "R4 fault after fourth" : "R5 gap of 128 discards count");
            end
        end

        // R7: fault hold, re-clear and release
        flush();
        repeat (4) seq(8'h01);
        chk(2'b01, "R7 fault entered");
        idle(100);
        seq(8'h01);
        idle(127);
        chk(2'b01, "R7 sequence re-clears counter");
        idle(1);
        chk(2'b00, "R7 release on 128th column");

        // R8: other kind inside fault
        flush();
        repeat (4) seq(8'h01);
        seq(8'h02);
        chk(2'b00, "R8 other kind clears status");
        seq(8'h02);
        seq(8'h02);
        chk(2'b00, "R8 new count needs four");
        seq(8'h02);
        chk(2'b10, "R8 fault of new kind");

        // R6: kind switch while counting
        flush();
        seq(8'h01); seq(8'h01); seq(8'h01);
        seq(8'h02); seq(8'h02); seq(8'h02);
        chk(2'b00, "R6 switch restarts count");
        seq(8'h02);
        chk(2'b10, "R6 fourth of new kind");
        flush();
        seq(8'h01); seq(8'h01); seq(8'h01); seq(8'h02); seq(8'h01);
        chk(2'b00, "R6 interleaved kinds never accumulate");

        // R2: lane 3 code sweep
        for (int v = 0; v < 16; v++) begin
            flush();
            repeat (4) seq(8'(v));
            chk(code_to_status(8'(v)), "R2 lane3 code sweep");
        end

        // R2: single-field corruptions of a local sequence
        for (int m = 0; m < 5; m++) begin
            logic [31:0] d;
            logic [3:0]  c;
            d = 32'h0100_009C;
            c = 4'b0001;
            case (m)
                0: c = 4'b0000;
                1: c = 4'b0011;
                2: d = 32'h0100_019C;
                3: d = 32'h0101_009C;
                default: d = 32'h0100_009D;
            endcase
            flush();
            repeat (4) col(1'b1, d, c);
            chk(2'b00, "R2 corrupted sequence ignored");
        end

        // R9: strobe-low columns
        flush();
        seq(8'h01); seq(8'h01); seq(8'h01);
        repeat (5) col(1'b0, 32'h0100_009C, 4'b0001);
        chk(2'b00, "R9 invalid sequences not counted");
        repeat (200) col(1'b0, IDLE_D, IDLE_C);
        seq(8'h01);
        chk(2'b01, "R9 invalid columns do not advance counter");
        repeat (300) col(1'b0, IDLE_D, IDLE_C);
        chk(2'b01, "R9 fault held across invalid columns");
        idle(127);
        chk(2'b01, "R9 127 valid columns keep fault");
        idle(1);
        chk(2'b00, "R9 release counts valid columns only");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule